// File: doc/BRIEF.md
# Inbound Virtual Wire Interrupt Group

This block keeps one group of four inbound virtual wires. A host-side link controller hands it wire updates, each tagged with a host index, a per-wire valid mask and four state bits. The group accepts an update only when the tag matches the host index that software programmed. Software programs the group through a small word-addressed register port. The port holds the host index, a selector that picks which of four reset domains reloads the wires, and a four-bit reload pattern.

Each wire has a 4-bit interrupt mode code. The code selects level-low, level-high, rising-edge, falling-edge or either-edge detection, or leaves the wire quiet. In a level mode the wire's interrupt output follows its state. In an edge mode the output shows a sticky pending flag, and software clears that flag by writing 1. A registered copy of each wire's previous state is used for edge detection. A reload from the chosen reset domain sets both the state and that copy, so a reload never raises an edge interrupt.

Top module: `vwin_group`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the configuration word reads 0x00000000, the mode word reads 0x04040404, the state word reads 0x00000000 and wire_irq is 0.
- R2: Register word select is reg_addr[3:2]: 0 = configuration, 1 = mode, 2 = state, 3 reads zero. The configuration word holds the host index in bits 7:0, the reset-domain selector in bits 9:8 and the reload pattern in bits 15:12 (bit 12+k for wire k). Every other bit reads 0.
- R3: When the selector holds value k, a 0-to-1 change of dom_rst[k] between two clock edges loads the reload pattern into the four wire states. A rising edge on any other dom_rst input changes nothing.
- R4: An update (upd_valid high) writes upd_state[k] into wire k only when upd_index equals the programmed host index and upd_mask[k] is 1. An update with a different index changes no wire.
- R5: An update is ignored whenever the programmed host index is below 2.
- R6: A reload and an accepted update in the same cycle leave the reload pattern in the wires. A reload sets no edge pending flag, even when it changes a wire.
- R7: The state word carries wire k's state in bit 8k and its edge pending flag in bit 8k+1. Writing 1 to bit 8k+1 clears that flag. Writes to the state bits have no effect.
- R8: Mode code 0 drives wire_irq[k] to the inverse of the wire state, and code 1 drives it to the wire state. Both take effect in the cycle after the state register changes.
- R9: Mode codes 13, 14 and 15 set the pending flag one cycle after a rising, falling or any change of the wire, respectively. A change in the other direction sets nothing. In these modes wire_irq[k] equals the pending flag.
- R10: Mode code 4 and every code not named in R8 or R9 hold wire_irq[k] at 0.
- R11: The mode word holds wire k's code in bits 8k+3:8k. All other bits of the mode word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| upd_valid | input | 1 | Wire update present this cycle |
| upd_index | input | 8 | Host index carried by the update |
| upd_mask | input | 4 | Per-wire valid bits of the update |
| upd_state | input | 4 | New wire states of the update |
| dom_rst | input | 4 | Candidate reset-domain inputs, sampled on clk |
| wire_irq | output | 4 | Interrupt output per wire |

## Verification
The bench targets the cases where a plausible mistake stays hidden. One is a reload that lands on a wire in either-edge mode: a design that does not clamp the previous-state copy would raise a spurious pending flag a cycle later. Another is a reload that arrives together with a matching update: the wrong priority would leave the update's bits in the wires. The bench also writes 1 to a state bit, which must not change the wire, and sends an update while the programmed index is below 2, which must be dropped. Opposite-direction edges in the single-edge modes and unlisted mode codes are exercised as well. A design that missed any of these would show an interrupt or a state bit the requirements forbid.

// File: rtl/vwin_pkg.sv
// Package: shared widths, detection-mode encoding and code decoder for the
// inbound virtual wire group. Assumes the 32-bit register layout with one
// 8-bit lane per wire.
package vwin_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned CODE_W    = 4;
    localparam int unsigned IDX_W     = 8;
    localparam int unsigned MIN_INDEX = 2;

    // Internal detection behaviour derived from a sparse 4-bit code
    typedef enum logic [2:0] {
        DET_OFF,
        DET_LOW,
        DET_HIGH,
        DET_RISE,
        DET_FALL,
        DET_BOTH
    } det_mode_t;

    localparam logic [CODE_W-1:0] CODE_LOW  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_HIGH = 4'd1;
    localparam logic [CODE_W-1:0] CODE_OFF  = 4'd4;
    localparam logic [CODE_W-1:0] CODE_RISE = 4'd13;
    localparam logic [CODE_W-1:0] CODE_FALL = 4'd14;
    localparam logic [CODE_W-1:0] CODE_BOTH = 4'd15;

    // Map a stored mode code onto a detection behaviour; unknown codes are quiet
    function automatic det_mode_t decode_mode(input logic [CODE_W-1:0] code);
        case (code)
            CODE_LOW:  return DET_LOW;
            CODE_HIGH: return DET_HIGH;
            CODE_RISE: return DET_RISE;
            CODE_FALL: return DET_FALL;
            CODE_BOTH: return DET_BOTH;
            default:   return DET_OFF;
        endcase
    endfunction

endpackage

// File: rtl/vwin_cfg_regs.sv
// Module: configuration storage for one wire group. It holds the host index,
// the reset-domain selector, the reload pattern and the raw mode code of each
// wire. Assumes the caller decodes the address into the two write strobes.
module vwin_cfg_regs
    import vwin_pkg::*;
#(
    parameter int unsigned NUM_WIRES = 4,
    parameter int unsigned NUM_DOMS  = 4,
    localparam int unsigned SRC_W    = $clog2(NUM_DOMS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_cfg,
    input  logic                              wr_mode,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [IDX_W-1:0]                  host_idx,
    output logic [SRC_W-1:0]                  dom_sel,
    output logic [NUM_WIRES-1:0]              reload_pat,
    output logic [NUM_WIRES-1:0][CODE_W-1:0]  mode_code
);

    localparam int unsigned SRC_LSB = 8;
    localparam int unsigned PAT_LSB = 12;

    // Configuration word: index, selector, reload pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_idx   <= '0;
            dom_sel    <= '0;
            reload_pat <= '0;
        end else if (wr_cfg) begin
            host_idx   <= wdata[IDX_W-1:0];
            dom_sel    <= wdata[SRC_LSB +: SRC_W];
            reload_pat <= wdata[PAT_LSB +: NUM_WIRES];
        end
    end

    // Mode word: one code per wire lane, reset to the disabled code
    generate
        for (genvar k = 0; k < NUM_WIRES; k++) begin : g_mode
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_code[k] <= CODE_OFF;
                else if (wr_mode)
                    mode_code[k] <= wdata[k*LANE_W +: CODE_W];
            end
        end
    endgenerate

endmodule

// File: rtl/vwin_rst_pick.sv
// Module: reset-domain reload detector. It samples every candidate domain
// input on clk and pulses reload for one cycle when the selected input goes
// from 0 to 1. Assumes the domain inputs are already synchronous to clk.
module vwin_rst_pick #(
    parameter int unsigned NUM_DOMS = 4,
    localparam int unsigned SRC_W   = $clog2(NUM_DOMS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DOMS-1:0] dom_in,
    input  logic [SRC_W-1:0]    dom_sel,
    output logic                reload
);

    logic [NUM_DOMS-1:0] dom_q;
    logic [NUM_DOMS-1:0] dom_rise;

    // Keep last sampled level of every domain input
    always_ff @(posedge clk) begin
        if (!rst_n) dom_q <= '0;
        else        dom_q <= dom_in;
    end

    // Rising-edge vector and selection of the chosen domain
    always_comb begin
        dom_rise = dom_in & ~dom_q;
        reload   = dom_rise[dom_sel];
    end

    // R3: one rising edge gives exactly one reload pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && $stable(dom_sel)) |=> !reload)
        else $error("reload pulse lasted more than one cycle");

endmodule

// File: rtl/vwin_wire_slice.sv
// Module: one virtual wire. It holds the state, the previous-state copy used
// for edge detection and the sticky edge pending flag, and it drives the
// wire's interrupt from its decoded mode. Assumes reload and update never
// need to be merged: reload wins.
module vwin_wire_slice
    import vwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              reload_bit,
    input  logic              upd_we,
    input  logic              upd_bit,
    input  logic              clr_pend,
    input  logic [CODE_W-1:0] mode_code,
    output logic              state_o,
    output logic              pend_o,
    output logic              irq_o
);

    logic      st_q;
    logic      prev_q;
    logic      pend_q;
    logic      went_up;
    logic      went_down;
    logic      edge_hit;
    det_mode_t mode;

    // Decode the code and classify the last state change
    always_comb begin
        mode      = decode_mode(mode_code);
        went_up   = st_q & ~prev_q;
        went_down = ~st_q & prev_q;
        edge_hit  = (went_up   && (mode == DET_RISE || mode == DET_BOTH)) ||
                    (went_down && (mode == DET_FALL || mode == DET_BOTH));
    end

    // Wire state and its previous copy; reload sets both so no edge appears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= 1'b0;
            prev_q <= 1'b0;
        end else if (reload) begin
            st_q   <= reload_bit;
            prev_q <= reload_bit;
        end else begin
            prev_q <= st_q;
            if (upd_we) st_q <= upd_bit;
        end
    end

    // Sticky pending flag: a new edge takes priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= edge_hit | (pend_q & ~clr_pend);
    end

    // Interrupt output selected by detection mode
    always_comb begin
        case (mode)
            DET_LOW:                     irq_o = ~st_q;
            DET_HIGH:                    irq_o = st_q;
            DET_RISE, DET_FALL, DET_BOTH: irq_o = pend_q;
            default:                     irq_o = 1'b0;
        endcase
    end

    assign state_o = st_q;
    assign pend_o  = pend_q;

    // R4: an accepted update without reload lands in the state
    a_r4_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && !reload) |=> (st_q == $past(upd_bit)))
        else $error("accepted update not stored");

    // R6: reload wins over a simultaneous update
    a_r6_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q == $past(reload_bit)))
        else $error("reload pattern not stored");

    // R6: a reload raises no pending flag in the cycle that follows it
    a_r6_reload_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> ##1 !$rose(pend_q))
        else $error("reload raised an edge pending flag");

    // R7: a clear with no new edge drops the flag
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !edge_hit) |=> !pend_q)
        else $error("pending flag survived a clear");

    // R10: quiet modes never assert the interrupt
    a_r10_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DET_OFF) |-> !irq_o)
        else $error("interrupt asserted in a quiet mode");

endmodule

// File: rtl/vwin_group.sv
// Module: top of one inbound virtual wire group. It decodes the register
// port, filters wire updates by host index and mask, picks the reload domain
// and instantiates one slice per wire. Assumes a fixed 8-bit lane per wire in
// the mode and state words, so NUM_WIRES may not exceed 4.
module vwin_group
    import vwin_pkg::*;
#(
    parameter int unsigned NUM_WIRES = 4,
    parameter int unsigned NUM_DOMS  = 4,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 upd_valid,
    input  logic [IDX_W-1:0]     upd_index,
    input  logic [NUM_WIRES-1:0] upd_mask,
    input  logic [NUM_WIRES-1:0] upd_state,
    input  logic [NUM_DOMS-1:0]  dom_rst,
    output logic [NUM_WIRES-1:0] wire_irq
);

    localparam int unsigned SRC_W   = $clog2(NUM_DOMS);
    localparam int unsigned SRC_LSB = 8;
    localparam int unsigned PAT_LSB = 12;
    localparam logic [1:0]  W_CFG   = 2'd0;
    localparam logic [1:0]  W_MODE  = 2'd1;
    localparam logic [1:0]  W_STATE = 2'd2;

    logic [1:0]                       word_sel;
    logic                             wr_cfg;
    logic                             wr_mode;
    logic                             wr_state;
    logic [IDX_W-1:0]                 host_idx;
    logic [SRC_W-1:0]                 dom_sel;
    logic [NUM_WIRES-1:0]             reload_pat;
    logic [NUM_WIRES-1:0][CODE_W-1:0] mode_code;
    logic                             reload;
    logic                             upd_hit;
    logic [NUM_WIRES-1:0]             upd_we;
    logic [NUM_WIRES-1:0]             clr_pend;
    logic [NUM_WIRES-1:0]             wire_st;
    logic [NUM_WIRES-1:0]             wire_pend;

    // Register word decode and write strobes
    always_comb begin
        word_sel = reg_addr[3:2];
        wr_cfg   = reg_wr && (word_sel == W_CFG);
        wr_mode  = reg_wr && (word_sel == W_MODE);
        wr_state = reg_wr && (word_sel == W_STATE);
    end

    // Update filter: matching index, index at least the minimum, per-wire mask
    always_comb begin
        upd_hit = upd_valid && (upd_index == host_idx) &&
                  (host_idx >= IDX_W'(MIN_INDEX));
        upd_we  = {NUM_WIRES{upd_hit}} & upd_mask;
    end

    vwin_cfg_regs #(
        .NUM_WIRES (NUM_WIRES),
        .NUM_DOMS  (NUM_DOMS)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg     (wr_cfg),
        .wr_mode    (wr_mode),
        .wdata      (reg_wdata),
        .host_idx   (host_idx),
        .dom_sel    (dom_sel),
        .reload_pat (reload_pat),
        .mode_code  (mode_code)
    );

    vwin_rst_pick #(
        .NUM_DOMS (NUM_DOMS)
    ) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .dom_in  (dom_rst),
        .dom_sel (dom_sel),
        .reload  (reload)
    );

    generate
        for (genvar k = 0; k < NUM_WIRES; k++) begin : g_wire
            // Write-one-to-clear bit sits just above the state bit of the lane
            assign clr_pend[k] = wr_state && reg_wdata[k*LANE_W + 1];

            vwin_wire_slice u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .reload     (reload),
                .reload_bit (reload_pat[k]),
                .upd_we     (upd_we[k]),
                .upd_bit    (upd_state[k]),
                .clr_pend   (clr_pend[k]),
                .mode_code  (mode_code[k]),
                .state_o    (wire_st[k]),
                .pend_o     (wire_pend[k]),
                .irq_o      (wire_irq[k])
            );
        end
    endgenerate

    // Read-data multiplexer assembling the selected word
    always_comb begin
        reg_rdata = '0;
        case (word_sel)
            W_CFG: begin
                reg_rdata[IDX_W-1:0]           = host_idx;
                reg_rdata[SRC_LSB +: SRC_W]    = dom_sel;
                reg_rdata[PAT_LSB +: NUM_WIRES] = reload_pat;
            end
            W_MODE: begin
                for (int k = 0; k < NUM_WIRES; k++)
                    reg_rdata[k*LANE_W +: CODE_W] = mode_code[k];
            end
            W_STATE: begin
                for (int k = 0; k < NUM_WIRES; k++) begin
                    reg_rdata[k*LANE_W]     = wire_st[k];
                    reg_rdata[k*LANE_W + 1] = wire_pend[k];
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    // R4: an update carrying a foreign index leaves every wire unchanged
    a_r4_foreign_index: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_index != host_idx) && !reload) |=> $stable(wire_st))
        else $error("foreign-index update changed a wire");

    // R5: below the minimum index no update reaches the wires
    a_r5_low_index: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (host_idx < IDX_W'(MIN_INDEX)) && !reload) |=> $stable(wire_st))
        else $error("update accepted with index below minimum");

endmodule

// File: tb/sim_vwin_group.sv
`timescale 1ns/1ps
module sim_vwin_group;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        upd_valid = 1'b0;
    logic [7:0]  upd_index = '0;
    logic [3:0]  upd_mask = '0;
    logic [3:0]  upd_state = '0;
    logic [3:0]  dom_rst = '0;
    logic [3:0]  wire_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Scoreboard queues: kind 0 = register word, 1 = interrupt vector
    bit          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    vwin_group u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .upd_valid (upd_valid),
        .upd_index (upd_index),
        .upd_mask  (upd_mask),
        .upd_state (upd_state),
        .dom_rst   (dom_rst),
        .wire_irq  (wire_irq)
    );

    // Monitor: pops expected items just after each falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                bit          k;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = k ? {28'd0, wire_irq} : reg_rdata;
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", t, a, e);
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic upd(input logic [7:0] idx, input logic [3:0] m, input logic [3:0] v);
        @(negedge clk);
        upd_valid = 1'b1; upd_index = idx; upd_mask = m; upd_state = v;
        @(negedge clk);
        upd_valid = 1'b0; upd_mask = '0;
    endtask

    task automatic pulse_dom(input int d);
        @(negedge clk);
        dom_rst[d] = 1'b1;
        @(negedge clk);
        dom_rst[d] = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic [3:0] e, input string t);
        @(negedge clk);
        q_kind.push_back(1'b1); q_exp.push_back({28'd0, e}); q_tag.push_back(t);
        @(negedge clk);
    endtask

    // Driver: stimulus with expected results from the requirements
    initial begin
        idle(3);
        rst_n = 1'b1;
        exp_rd(4'h0, 32'h0000_0000, "R1 cfg reset");
        exp_rd(4'h4, 32'h0404_0404, "R1 mode reset");
        exp_rd(4'h8, 32'h0000_0000, "R1 state reset");
        exp_irq(4'b0000, "R1 irq reset");
        exp_rd(4'hC, 32'h0000_0000, "R2 unused word");

        wr(4'h0, 32'h00FF_A105);
        exp_rd(4'h0, 32'h0000_A105, "R2 cfg readback");
        wr(4'h4, 32'hFF0D_F0F1);
        exp_rd(4'h4, 32'h0F0D_0001, "R11 mode readback");
        exp_irq(4'b0010, "R8 low level on zero wire");

        upd(8'h05, 4'hF, 4'b0101);
        idle(1);
        exp_rd(4'h8, 32'h0003_0001, "R9 rising pending");
        exp_irq(4'b0111, "R8 R9 irq after update");

        upd(8'h06, 4'hF, 4'b1111);
        idle(1);
        exp_rd(4'h8, 32'h0003_0001, "R4 foreign index ignored");

        upd(8'h05, 4'b1000, 4'b1111);
        idle(1);
        exp_rd(4'h8, 32'h0303_0001, "R4 mask limits update");
        exp_irq(4'b1111, "R9 either edge irq");

        wr(4'h8, 32'h0002_0100);
        exp_rd(4'h8, 32'h0301_0001, "R7 w1c and state bits read-only");
        exp_irq(4'b1011, "R7 irq after clear");

        wr(4'h8, 32'h0200_0000);
        upd(8'h05, 4'b1100, 4'b0000);
        idle(1);
        exp_rd(4'h8, 32'h0200_0001, "R9 fall on rising mode ignored");
        exp_irq(4'b1011, "R9 either edge fall");

        wr(4'h4, 32'h0F0E_0704);
        exp_rd(4'h4, 32'h0F0E_0704, "R11 new codes");
        exp_irq(4'b1000, "R10 disabled and unlisted quiet");
        upd(8'h05, 4'b0100, 4'b0100);
        idle(1);
        exp_rd(4'h8, 32'h0201_0001, "R9 rise on falling mode ignored");
        upd(8'h05, 4'b0100, 4'b0000);
        idle(1);
        exp_rd(4'h8, 32'h0202_0001, "R9 falling pending");
        exp_irq(4'b1100, "R9 falling irq");

        wr(4'h8, 32'h0202_0000);
        exp_rd(4'h8, 32'h0000_0001, "R7 both cleared");
        pulse_dom(0);
        idle(1);
        exp_rd(4'h8, 32'h0000_0001, "R3 other domain ignored");
        pulse_dom(1);
        idle(2);
        exp_rd(4'h8, 32'h0100_0100, "R3 R6 reload without edge");
        exp_irq(4'b0000, "R6 no irq from reload");

        wr(4'h0, 32'h0000_A101);
        upd(8'h01, 4'hF, 4'b0000);
        idle(1);
        exp_rd(4'h8, 32'h0100_0100, "R5 index below minimum");

        wr(4'h0, 32'h0000_A105);
        @(negedge clk);
        upd_valid = 1'b1; upd_index = 8'h05; upd_mask = 4'hF; upd_state = 4'b0101;
        dom_rst[1] = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0; upd_mask = '0; dom_rst[1] = 1'b0;
        idle(2);
        exp_rd(4'h8, 32'h0100_0100, "R6 reload beats update");

        upd(8'h05, 4'hF, 4'b0000);
        idle(1);
        exp_rd(4'h8, 32'h0200_0000, "R4 accepted update");
        exp_irq(4'b1000, "R9 either fall after reload");

        wr(4'h8, 32'h0200_0000);
        wr(4'h0, 32'h0000_5305);
        exp_rd(4'h0, 32'h0000_5305, "R2 selector three");
        pulse_dom(3);
        idle(2);
        exp_rd(4'h8, 32'h0001_0001, "R3 platform-domain reload");
        exp_irq(4'b0000, "R6 quiet after second reload");

        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        exp_rd(4'h4, 32'h0404_0404, "R1 mode after second reset");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule